// File: doc/BRIEF.md
# Serial Channel Clock Source Router

This block routes clocks for one serial channel. A single control register picks the receive clock source and the transmit clock source. The candidates are an input-only clock pin (A), a bidirectional clock pin (B), the baud rate generator output and the DPLL outputs. The same register decides whether pin B is driven as an output and which internal clock it carries. A gated oscillator input is one of those choices. The oscillator, baud rate generator, DPLL, receiver and transmitter sit outside the block and reach it only as plain input signals.

The routing paths are combinational, and the control register sits in front of them. The receive path inverts clocks that come from either pin. Because the receiver samples on the falling edge of its internal clock, a rising edge on the pin becomes the sampling event. Clock selections must be settled before the downstream logic is enabled. A small guard state machine watches writes made while `run_en` is high and raises `sel_fault` if one of them changes the register.

The guard has three states:
- **G_IDLE**: downstream logic is disabled.
- **G_LIVE**: downstream logic is enabled and the selections are stable.
- **G_FAULT**: a selection changed while running.

Its transitions are:
- G_IDLE→G_LIVE when `run_en` is high and no changing write occurs.
- G_IDLE→G_FAULT and G_LIVE→G_FAULT when a changing write coincides with `run_en` high.
- G_LIVE→G_IDLE and G_FAULT→G_IDLE when `run_en` is low.
- Every other case holds the current state.

Top module: `serclk_router`

## Requirements
- R1: After reset the control register is all zero: `bpin_oe` is 0, `bpin_out` is 1 (gated oscillator selected while disabled) and `sel_fault` is 0.
- R2: When `wr_en` is high at a rising clock edge, `wr_data` is loaded into the control register. The field layout is: bit 7 oscillator enable, bits 6:5 transmit source, bits 4:3 receive source, bit 2 pin-B drive request, bits 1:0 pin-B output select.
- R3: `bpin_oe` is 1 exactly when bit 2 is 1 and neither source field equals 01 (pin B).
- R4: The pin-B output select encoding is: 00 gated oscillator, 01 transmit clock, 10 baud rate generator, 11 DPLL receive output.
- R5: When oscillator enable (bit 7) is 0, the gated oscillator is held high, so selecting it drives `bpin_out` to 1.
- R6: With output select 01 and transmit source 11, `bpin_out` follows `dpll_tx_in`.
- R7: The receive source encoding is: 00 pin A, 01 pin B, 10 baud rate generator, 11 `dpll_rx_in`. `rx_clk` is the inverse of the selected pin for codes 00 and 01, and is not inverted for codes 10 and 11.
- R8: The transmit source uses the same code values as R7, with 11 taking `dpll_tx_in`. `tx_clk` equals the selected signal with no inversion.
- R9: A write whose data differs from the current register value while `run_en` is 1 makes `sel_fault` 1 from the next cycle.
- R10: A write that does not change the register value, or any write while `run_en` is 0, leaves `sel_fault` at 0.
- R11: `sel_fault` stays 1 while `run_en` stays 1 and clears the cycle after `run_en` is seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| run_en | input | 1 | Downstream logic enabled flag |
| apin_in | input | 1 | Input-only clock pin A |
| bpin_in | input | 1 | Input side of bidirectional pin B |
| osc_in | input | 1 | Oscillator output |
| brg_in | input | 1 | Baud rate generator output |
| dpll_rx_in | input | 1 | DPLL receive clock output |
| dpll_tx_in | input | 1 | DPLL transmit clock output |
| bpin_out | output | 1 | Value driven onto pin B |
| bpin_oe | output | 1 | Output enable for pin B |
| rx_clk | output | 1 | Routed receiver clock |
| tx_clk | output | 1 | Routed transmitter clock |
| sel_fault | output | 1 | Selection changed while running |

## Verification
On every cycle the assertions check three things. First, the output enable after any write matches the drive bit and the pin-B exclusion. Second, a disabled and selected oscillator holds pin B high. Third, the guard raises its flag only after a changing write made while running, and drops it once running ends.

Only the bench's scenarios show the rest. That covers the full source and output-select encodings under random clock levels, the inversion of pin-sourced receive clocks, and the DPLL transmit clock appearing on pin B. It also covers the quiet cases where same-value writes or idle-time writes leave the flag low.

// File: rtl/serclk_pkg.sv
package serclk_pkg;
    localparam int SEL_W = 2;
    localparam int CTL_W = 8;

    typedef enum logic [SEL_W-1:0] {
        SRC_APIN = 2'd0,
        SRC_BPIN = 2'd1,
        SRC_BRG  = 2'd2,
        SRC_DPLL = 2'd3
    } src_e;

    typedef enum logic [SEL_W-1:0] {
        PO_OSC   = 2'd0,
        PO_TXCLK = 2'd1,
        PO_BRG   = 2'd2,
        PO_DPLL  = 2'd3
    } pinout_e;

    typedef struct packed {
        logic    osc_en;
        src_e    tx_src;
        src_e    rx_src;
        logic    pin_drv;
        pinout_e pin_sel;
    } ctl_t;

    typedef enum logic [1:0] {
        G_IDLE  = 2'd0,
        G_LIVE  = 2'd1,
        G_FAULT = 2'd2
    } guard_e;
endpackage

// File: rtl/serclk_ctl_reg.sv
module serclk_ctl_reg
    import serclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output ctl_t             ctl_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_en) begin
            ctl_q <= ctl_t'(wr_data);
        end
    end
endmodule

// File: rtl/serclk_sel4.sv
module serclk_sel4
    import serclk_pkg::*;
#(
    parameter bit PIN_INV = 1'b0
) (
    input  src_e sel,
    input  logic apin,
    input  logic bpin,
    input  logic brg,
    input  logic dpll,
    output logic clk_out
);
    logic raw;

    always_comb begin
        unique case (sel)
            SRC_APIN: raw = apin;
            SRC_BPIN: raw = bpin;
            SRC_BRG:  raw = brg;
            SRC_DPLL: raw = dpll;
            default:  raw = apin;
        endcase
    end

    generate
        if (PIN_INV) begin : g_inv
            logic pin_path;
            assign pin_path = (sel == SRC_APIN) || (sel == SRC_BPIN);
            assign clk_out  = pin_path ? ~raw : raw;
        end else begin : g_thru
            assign clk_out = raw;
        end
    endgenerate
endmodule

// File: rtl/serclk_route.sv
module serclk_route
    import serclk_pkg::*;
(
    input  ctl_t ctl,
    input  logic apin_in,
    input  logic bpin_in,
    input  logic osc_in,
    input  logic brg_in,
    input  logic dpll_rx_in,
    input  logic dpll_tx_in,
    output logic rx_clk,
    output logic tx_clk,
    output logic bpin_out,
    output logic bpin_oe
);
    logic osc_gated;

    serclk_sel4 #(.PIN_INV(1'b1)) rx_sel_i (
        .sel     (ctl.rx_src),
        .apin    (apin_in),
        .bpin    (bpin_in),
        .brg     (brg_in),
        .dpll    (dpll_rx_in),
        .clk_out (rx_clk)
    );

    serclk_sel4 #(.PIN_INV(1'b0)) tx_sel_i (
        .sel     (ctl.tx_src),
        .apin    (apin_in),
        .bpin    (bpin_in),
        .brg     (brg_in),
        .dpll    (dpll_tx_in),
        .clk_out (tx_clk)
    );

    assign osc_gated = ctl.osc_en ? osc_in : 1'b1;

    always_comb begin
        unique case (ctl.pin_sel)
            PO_OSC:   bpin_out = osc_gated;
            PO_TXCLK: bpin_out = tx_clk;
            PO_BRG:   bpin_out = brg_in;
            PO_DPLL:  bpin_out = dpll_rx_in;
            default:  bpin_out = osc_gated;
        endcase
    end

    assign bpin_oe = ctl.pin_drv
                   && (ctl.rx_src != SRC_BPIN)
                   && (ctl.tx_src != SRC_BPIN);
endmodule

// File: rtl/serclk_guard_fsm.sv
module serclk_guard_fsm
    import serclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  ctl_t             ctl_q,
    output logic             sel_fault
);
    guard_e state_q;
    guard_e state_d;
    logic   change_wr;

    assign change_wr = wr_en && (ctl_t'(wr_data) != ctl_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= G_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            G_IDLE: begin
                if (run_en) state_d = change_wr ? G_FAULT : G_LIVE;
            end
            G_LIVE: begin
                if (!run_en)       state_d = G_IDLE;
                else if (change_wr) state_d = G_FAULT;
            end
            G_FAULT: begin
                if (!run_en) state_d = G_IDLE;
            end
            default: state_d = G_IDLE;
        endcase
    end

    always_comb begin
        sel_fault = (state_q == G_FAULT);
    end
endmodule

// File: rtl/serclk_router.sv
module serclk_router
    import serclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             run_en,
    input  logic             apin_in,
    input  logic             bpin_in,
    input  logic             osc_in,
    input  logic             brg_in,
    input  logic             dpll_rx_in,
    input  logic             dpll_tx_in,
    output logic             bpin_out,
    output logic             bpin_oe,
    output logic             rx_clk,
    output logic             tx_clk,
    output logic             sel_fault
);
    ctl_t ctl_q;

    serclk_ctl_reg ctl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctl_q   (ctl_q)
    );

    serclk_route route_i (
        .ctl        (ctl_q),
        .apin_in    (apin_in),
        .bpin_in    (bpin_in),
        .osc_in     (osc_in),
        .brg_in     (brg_in),
        .dpll_rx_in (dpll_rx_in),
        .dpll_tx_in (dpll_tx_in),
        .rx_clk     (rx_clk),
        .tx_clk     (tx_clk),
        .bpin_out   (bpin_out),
        .bpin_oe    (bpin_oe)
    );

    serclk_guard_fsm guard_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ctl_q     (ctl_q),
        .sel_fault (sel_fault)
    );
endmodule

// File: rtl/serclk_router_chk.sv
module serclk_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       run_en,
    input logic       bpin_out,
    input logic       bpin_oe,
    input logic       sel_fault,
    input logic [7:0] ctl_q
);
    AST_OE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (bpin_oe == ($past(wr_data[2]) && ($past(wr_data[4:3]) != 2'b01)
                               && ($past(wr_data[6:5]) != 2'b01)))); // R3

    AST_OSC_OFF_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[7] && (wr_data[1:0] == 2'b00)) |=> bpin_out); // R5

    AST_FAULT_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && wr_en && (wr_data != ctl_q)) |=> sel_fault); // R9

    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_fault) |-> $past(run_en && wr_en)); // R10

    AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !sel_fault); // R11

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_fault && run_en) |=> sel_fault); // R11
endmodule

bind serclk_router serclk_router_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .run_en    (run_en),
    .bpin_out  (bpin_out),
    .bpin_oe   (bpin_oe),
    .sel_fault (sel_fault),
    .ctl_q     (ctl_q)
);

// File: tb/serclk_router_tb_top.sv
module serclk_router_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       run_en;
    logic       apin_in, bpin_in, osc_in, brg_in, dpll_rx_in, dpll_tx_in;
    logic       bpin_out, bpin_oe, rx_clk, tx_clk, sel_fault;

    int         n_cmp = 0;
    int         n_bad = 0;
    logic [7:0] m_ctl;
    bit         m_fault;
    string      fault_tag = "R10";

    always #2 clk = ~clk;

    serclk_router dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .run_en(run_en),
        .apin_in(apin_in), .bpin_in(bpin_in), .osc_in(osc_in), .brg_in(brg_in),
        .dpll_rx_in(dpll_rx_in), .dpll_tx_in(dpll_tx_in),
        .bpin_out(bpin_out), .bpin_oe(bpin_oe), .rx_clk(rx_clk), .tx_clk(tx_clk),
        .sel_fault(sel_fault)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b (ctl=%h)", req, what, act, exp, m_ctl);
        end
    endtask

    function automatic logic pick(input logic [1:0] s, input logic dp);
        case (s)
            2'd0:    return apin_in;
            2'd1:    return bpin_in;
            2'd2:    return brg_in;
            default: return dp;
        endcase
    endfunction

    task automatic compare();
        logic rx_e, tx_e, osc_e, pin_e, oe_e;
        string pin_tag;
        rx_e  = pick(m_ctl[4:3], dpll_rx_in);
        if (m_ctl[4:3] < 2'd2) rx_e = ~rx_e;
        tx_e  = pick(m_ctl[6:5], dpll_tx_in);
        osc_e = m_ctl[7] ? osc_in : 1'b1;
        case (m_ctl[1:0])
            2'd0:    pin_e = osc_e;
            2'd1:    pin_e = tx_e;
            2'd2:    pin_e = brg_in;
            default: pin_e = dpll_rx_in;
        endcase
        oe_e = m_ctl[2] && (m_ctl[4:3] != 2'd1) && (m_ctl[6:5] != 2'd1);
        if (m_ctl[1:0] == 2'd0)                           pin_tag = "R5";
        else if (m_ctl[1:0] == 2'd1 && m_ctl[6:5] == 2'd3) pin_tag = "R6";
        else                                               pin_tag = "R4";
        chk("R7", "rx_clk", rx_clk, rx_e);
        chk("R8", "tx_clk", tx_clk, tx_e);
        chk(pin_tag, "bpin_out", bpin_out, pin_e);
        chk("R3", "bpin_oe", bpin_oe, oe_e);
        chk(fault_tag, "sel_fault", sel_fault, m_fault);
    endtask

    // one cycle: drive at the falling edge, compare 1 ns later, update the model at the rising edge
    task automatic step(input bit we, input logic [7:0] d, input bit run);
        wr_en   = we;
        wr_data = d;
        run_en  = run;
        {apin_in, bpin_in, osc_in, brg_in, dpll_rx_in, dpll_tx_in} = 6'($urandom);
        #1;
        compare();
        @(posedge clk);
        if (!run)                     m_fault = 1'b0;
        else if (we && (d != m_ctl))  m_fault = 1'b1;
        if (we) m_ctl = d;
        @(negedge clk);
    endtask

    task automatic wr_hold(input logic [7:0] d, input int n);
        step(1'b1, d, 1'b0);
        for (int k = 0; k < n; k++) step(1'b0, 8'h00, 1'b0);
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; run_en = 1'b0;
        {apin_in, bpin_in, osc_in, brg_in, dpll_rx_in, dpll_tx_in} = '0;
        m_ctl = '0; m_fault = 1'b0;
        repeat (3) @(negedge clk);
        osc_in = 1'b0;
        #1;
        chk("R1", "reset bpin_oe", bpin_oe, 1'b0);
        chk("R1", "reset bpin_out", bpin_out, 1'b1);
        chk("R1", "reset sel_fault", sel_fault, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) step(1'b0, 8'h00, 1'b0);

        // R2 R4 R5: every output select, oscillator on and off, pin B free
        for (int o = 0; o < 2; o++)
            for (int s = 0; s < 4; s++)
                wr_hold({o[0], 2'b00, 2'b00, 1'b1, s[1:0]}, 6);

        // R3 R6 R7 R8: all receive and transmit source pairs, transmit clock on pin B
        for (int r = 0; r < 4; r++)
            for (int t = 0; t < 4; t++)
                wr_hold({1'b1, t[1:0], r[1:0], 1'b1, 2'b01}, 6);

        // drive bit cleared: pin stays an input
        wr_hold(8'b1_11_10_0_11, 4);

        // R10: same-value writes while running, changing writes while idle
        fault_tag = "R10";
        wr_hold(8'b1_10_00_1_10, 2);
        for (int k = 0; k < 6; k++) step(1'b1, 8'b1_10_00_1_10, 1'b1);
        step(1'b0, 8'h00, 1'b0);
        step(1'b1, 8'b0_11_11_1_00, 1'b0);
        step(1'b1, 8'b1_00_10_1_01, 1'b0);

        // R9 then R11: changing write while running, hold, then release
        fault_tag = "R9";
        step(1'b0, 8'h00, 1'b1);
        step(1'b1, 8'b1_11_10_1_01, 1'b1);
        fault_tag = "R11";
        for (int k = 0; k < 5; k++) step(1'b0, 8'h00, 1'b1);
        step(1'b1, 8'b1_11_10_1_01, 1'b1);
        step(1'b0, 8'h00, 1'b0);
        for (int k = 0; k < 3; k++) step(1'b0, 8'h00, 1'b0);

        // R9: change in the very cycle running starts
        fault_tag = "R9";
        step(1'b1, 8'b0_01_00_1_00, 1'b1);
        for (int k = 0; k < 3; k++) step(1'b0, 8'h00, 1'b1);
        fault_tag = "R11";
        for (int k = 0; k < 3; k++) step(1'b0, 8'h00, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule